// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides what the processor state looks like after a reset, a general exception, a trap instruction, a TLB fault, a TLB multi-hit or an accepted interrupt. Each request arrives as a single-cycle `req_valid` pulse. The pulse carries an event class and a code, together with a snapshot of the current program counter, status word, R15, vector base and page-table-entry-high register.

On the next clock edge the sequencer registers several things. It registers the branch target and the following fetch address. It registers the new status word and vector base. It registers the saved copies of PC, status and R15. It also registers the event-code, trap-code, fault-address and page-table-entry-high values.

A one-cycle `upd` strobe marks the cycle in which the core should take these values. The strobe also tells the core to clear its delay-slot state. Choosing between competing interrupt sources and looking up the TLB are both done outside this block.

Class encoding on `req_class`:
- 0: power-on reset
- 1: manual reset
- 2: general exception
- 3: trap
- 4: TLB fault
- 5: TLB multi-hit
- 6: interrupt
- 7: treated as a general exception

Status bit positions:
- MD (privileged mode): bit 30
- RB (register bank): bit 29
- BL (block): bit 28
- FD (FPU disable): bit 15
- Interrupt mask: bits 7:4

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, and until the first request, `upd` and `fpscr_wr` are 0 and every register output reads 0.
- R2: A power-on reset (class 0) produces the following outputs, and leaves the saved PC, saved status and saved R15 unchanged:
  - `new_pc` = 0xA0000000
  - `new_vbr` = 0
  - `new_sr` = 0x700000F0
  - `expevt` = 0x000
  - `fpscr_wr` = 1 and `new_fpscr` = 0x00040001
- R3: A manual reset (class 1) produces the following outputs, and leaves the saved registers unchanged:
  - `new_pc` = 0xA0000000
  - `new_vbr` = 0
  - `expevt` = 0x020
  - `new_sr` = (`cur_sr` | 0x700000F0) with bit 15 cleared
- R4: A general exception (class 2) taken while `cur_sr` bit 28 is 0 does the following:
  - saves `cur_pc`, `cur_sr` and `cur_r15`
  - writes `req_code` to `expevt`
  - jumps to `cur_vbr` + 0x100
  - sets `new_sr` = `cur_sr` | 0x70000000
- R5: A general exception taken while `cur_sr` bit 28 is 1 is escalated to a manual reset, with exactly the R3 outputs and no save.
- R6: A trap (class 3) does the following, whatever the state of bit 28:
  - saves PC, status and R15, as in R4
  - writes `{req_code[7:0], 2'b00}` to `tra`
  - writes 0x160 to `expevt`
  - jumps to `cur_vbr` + 0x100
- R7: A TLB fault (class 4) does the following:
  - saves PC, status and R15
  - writes `req_addr` to `tea`
  - sets `pteh` = `{req_addr[31:10], cur_pteh[9:0]}`
  - writes `req_code` to `expevt`
  - jumps to `cur_vbr` + 0x400
- R8: A TLB multi-hit (class 5) updates `tea` and `pteh` as in R7, then follows the R3 reset path with `expevt` = 0x140.
- R9: An accepted interrupt (class 6) does the following, and leaves `expevt` unchanged:
  - saves PC, status and R15
  - writes `req_code` to `intevt`
  - jumps to `cur_vbr` + 0x600
  - sets the status word as in R4
- R10: For every request, `upd` and `dslot_clr` are high exactly in the cycle after the request, and `new_npc` = `new_pc` + 2. Back-to-back requests give back-to-back strobes.
- R11: Registers that an entry does not target keep their previous values: `tra`, `tea`, `pteh`, `intevt`, `expevt` and the saved registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Event request strobe |
| req_class | input | 3 | Event class |
| req_code | input | 12 | Event code, trap immediate or interrupt code |
| req_addr | input | 32 | Faulting virtual address |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | 32 | Current stack register |
| cur_vbr | input | 32 | Current vector base |
| cur_pteh | input | 32 | Current page-table-entry-high value |
| upd | output | 1 | Update strobe |
| dslot_clr | output | 1 | Clear delay-slot indicator |
| new_pc | output | 32 | Branch target |
| new_npc | output | 32 | Following fetch address |
| new_sr | output | 32 | New status word |
| new_vbr | output | 32 | New vector base |
| new_fpscr | output | 32 | Floating-point control value for power-on |
| fpscr_wr | output | 1 | Load `new_fpscr` |
| saved_pc | output | 32 | Saved program counter |
| saved_sr | output | 32 | Saved status word |
| saved_r15 | output | 32 | Saved stack register |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| tra | output | 10 | Trap code |
| tea | output | 32 | Fault address |
| pteh | output | 32 | Page-table-entry-high value |

## Verification
Every output register is loaded exactly once per request and is otherwise held, so a wrong decode or a stale value appears at the ports in the first `upd` cycle after the offending request. There is no hidden pipeline state that could delay the symptom.

The riskiest internal decision is classifying an entry as a reset path rather than a normal vectored entry. A wrong choice shows at once in three places: a PC of 0xA0000000 versus a VBR-relative target, a changed or unchanged saved-register set, and the state of the FD bit. A lost or duplicated strobe shows as a scoreboard item left over or missing.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int          CW       = 12,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] VEC_GEN  = 32'h0000_0100,
  parameter logic [31:0] VEC_TLB  = 32'h0000_0400,
  parameter logic [31:0] VEC_IRQ  = 32'h0000_0600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_class,
  input  logic [CW-1:0] req_code,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   cur_pc,
  input  logic [31:0]   cur_sr,
  input  logic [31:0]   cur_r15,
  input  logic [31:0]   cur_vbr,
  input  logic [31:0]   cur_pteh,
  output logic          upd,
  output logic          dslot_clr,
  output logic [31:0]   new_pc,
  output logic [31:0]   new_npc,
  output logic [31:0]   new_sr,
  output logic [31:0]   new_vbr,
  output logic [31:0]   new_fpscr,
  output logic          fpscr_wr,
  output logic [31:0]   saved_pc,
  output logic [31:0]   saved_sr,
  output logic [31:0]   saved_r15,
  output logic [CW-1:0] expevt,
  output logic [CW-1:0] intevt,
  output logic [9:0]    tra,
  output logic [31:0]   tea,
  output logic [31:0]   pteh
);
  localparam logic [2:0] C_POR = 3'd0, C_MRST = 3'd1, C_GEN = 3'd2, C_TRAP = 3'd3,
                         C_TLB = 3'd4, C_MHIT = 3'd5, C_IRQ = 3'd6;
  localparam int BL = 28, FD = 15;
  localparam logic [31:0] ENTRY_SET = 32'h7000_0000;
  localparam logic [31:0] RST_SET   = 32'h7000_00F0;
  localparam logic [31:0] POR_SR    = 32'h7000_00F0;
  localparam logic [CW-1:0] EV_POR  = CW'(12'h000);
  localparam logic [CW-1:0] EV_MRST = CW'(12'h020);
  localparam logic [CW-1:0] EV_MHIT = CW'(12'h140);
  localparam logic [CW-1:0] EV_TRAP = CW'(12'h160);

  logic          go_reset, tlb_touch, rst_kind_q;
  logic [31:0]   target;
  logic [CW-1:0] rst_code;

  assign go_reset  = (req_class == C_POR) || (req_class == C_MRST) || (req_class == C_MHIT) ||
                     ((req_class == C_GEN || req_class == 3'd7) && cur_sr[BL]);
  assign tlb_touch = (req_class == C_TLB) || (req_class == C_MHIT);
  assign rst_code  = (req_class == C_POR) ? EV_POR : (req_class == C_MHIT) ? EV_MHIT : EV_MRST;
  assign new_fpscr = 32'h0004_0001;
  assign dslot_clr = upd;

  always_comb begin
    if (go_reset)                  target = RESET_PC;
    else if (req_class == C_TLB)   target = cur_vbr + VEC_TLB;
    else if (req_class == C_IRQ)   target = cur_vbr + VEC_IRQ;
    else                           target = cur_vbr + VEC_GEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd <= 1'b0; rst_kind_q <= 1'b0; fpscr_wr <= 1'b0;
      new_pc <= '0; new_npc <= '0; new_sr <= '0; new_vbr <= '0;
      saved_pc <= '0; saved_sr <= '0; saved_r15 <= '0;
      expevt <= '0; intevt <= '0; tra <= '0; tea <= '0; pteh <= '0;
    end else begin
      upd        <= req_valid;
      rst_kind_q <= req_valid && go_reset;
      fpscr_wr   <= req_valid && (req_class == C_POR);
      if (req_valid) begin
        new_pc  <= target;
        new_npc <= target + 32'd2;
        if (tlb_touch) begin
          tea  <= req_addr;
          pteh <= {req_addr[31:10], cur_pteh[9:0]};
        end
        if (go_reset) begin
          new_vbr <= '0;
          expevt  <= rst_code;
          new_sr  <= (req_class == C_POR) ? POR_SR : ((cur_sr | RST_SET) & ~(32'd1 << FD));
        end else begin
          saved_pc  <= cur_pc;
          saved_sr  <= cur_sr;
          saved_r15 <= cur_r15;
          new_sr    <= cur_sr | ENTRY_SET;
          new_vbr   <= cur_vbr;
          case (req_class)
            C_TRAP: begin tra <= {req_code[7:0], 2'b00}; expevt <= EV_TRAP; end
            C_IRQ:  intevt <= req_code;
            default: expevt <= req_code;
          endcase
        end
      end
    end
  end

  a_r10_npc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> new_npc == new_pc + 32'd2);
  a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> new_sr[30:28] == 3'b111);
  a_r3_reset_path: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && rst_kind_q) |-> (!new_sr[FD] && new_vbr == 32'd0 && new_pc == RESET_PC));
  a_r5_no_save_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == C_GEN && cur_sr[BL]) |=> ($stable(saved_pc) && $stable(saved_sr) && $stable(saved_r15)));
  a_r9_irq_keeps_expevt: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == C_IRQ) |=> $stable(expevt));
  a_r6_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == C_TRAP) |=> (tra[1:0] == 2'b00 && new_pc != RESET_PC));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_class = '0;
  logic [11:0] req_code = '0;
  logic [31:0] req_addr = '0, cur_pc = '0, cur_sr = '0, cur_r15 = '0, cur_vbr = '0, cur_pteh = '0;
  logic upd, dslot_clr, fpscr_wr;
  logic [31:0] new_pc, new_npc, new_sr, new_vbr, new_fpscr, saved_pc, saved_sr, saved_r15, tea, pteh;
  logic [11:0] expevt, intevt;
  logic [9:0] tra;

  always #4 clk = ~clk;

  exc_entry_seq dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_code(req_code), .req_addr(req_addr), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
    .cur_vbr(cur_vbr), .cur_pteh(cur_pteh), .upd(upd), .dslot_clr(dslot_clr), .new_pc(new_pc),
    .new_npc(new_npc), .new_sr(new_sr), .new_vbr(new_vbr), .new_fpscr(new_fpscr), .fpscr_wr(fpscr_wr),
    .saved_pc(saved_pc), .saved_sr(saved_sr), .saved_r15(saved_r15), .expevt(expevt), .intevt(intevt),
    .tra(tra), .tea(tea), .pteh(pteh));

  typedef struct {
    logic [31:0] pc, sr, vbr, spc, ssr, sgr, tea, pteh;
    logic [11:0] ev, iev;
    logic [9:0]  tra;
    logic        fw;
    string       tag;
  } item_t;

  item_t q[$];
  item_t m;
  int n_chk = 0, n_bad = 0;

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic send(logic [2:0] cls, logic [11:0] code, logic [31:0] addr, logic [31:0] pc,
                      logic [31:0] sr, logic [31:0] r15, logic [31:0] vbr, logic [31:0] pt, string tag);
    bit rst_path;
    rst_path = (cls == 0) || (cls == 1) || (cls == 5) || (cls == 2 && sr[28]);
    m.tag = tag;
    m.fw = (cls == 0);
    if (cls == 4 || cls == 5) begin
      m.tea = addr;
      m.pteh = (addr & 32'hFFFF_FC00) | (pt & 32'h3FF);
    end
    if (rst_path) begin
      m.pc = 32'hA000_0000;
      m.vbr = 0;
      m.ev = (cls == 0) ? 12'h000 : (cls == 5) ? 12'h140 : 12'h020;
      m.sr = (cls == 0) ? 32'h7000_00F0 : ((sr | 32'h7000_00F0) & 32'hFFFF_7FFF);
    end else begin
      m.spc = pc; m.ssr = sr; m.sgr = r15;
      m.sr = sr | 32'h7000_0000;
      m.vbr = vbr;
      case (cls)
        3: begin m.pc = vbr + 32'h100; m.tra = {code[7:0], 2'b00}; m.ev = 12'h160; end
        4: begin m.pc = vbr + 32'h400; m.ev = code; end
        6: begin m.pc = vbr + 32'h600; m.iev = code; end
        default: begin m.pc = vbr + 32'h100; m.ev = code; end
      endcase
    end
    q.push_back(m);
    @(negedge clk);
    req_valid = 1'b1; req_class = cls; req_code = code; req_addr = addr;
    cur_pc = pc; cur_sr = sr; cur_r15 = r15; cur_vbr = vbr; cur_pteh = pt;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 spurious upd: actual 1 expected 0");
      end else begin
        item_t e;
        e = q.pop_front();
        chk(e.tag, "new_pc", new_pc, e.pc);
        chk("R10", "new_npc", new_npc, e.pc + 32'd2);
        chk("R10", "dslot_clr", {31'd0, dslot_clr}, 32'd1);
        chk(e.tag, "new_sr", new_sr, e.sr);
        chk(e.tag, "new_vbr", new_vbr, e.vbr);
        chk(e.tag, "saved_pc", saved_pc, e.spc);
        chk(e.tag, "saved_sr", saved_sr, e.ssr);
        chk(e.tag, "saved_r15", saved_r15, e.sgr);
        chk(e.tag, "expevt", {20'd0, expevt}, {20'd0, e.ev});
        chk(e.tag, "intevt", {20'd0, intevt}, {20'd0, e.iev});
        chk(e.tag, "tra", {22'd0, tra}, {22'd0, e.tra});
        chk(e.tag, "tea", tea, e.tea);
        chk(e.tag, "pteh", pteh, e.pteh);
        chk(e.tag, "fpscr_wr", {31'd0, fpscr_wr}, {31'd0, e.fw});
        if (e.fw) chk("R2", "new_fpscr", new_fpscr, 32'h0004_0001);
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m = '{pc:0, sr:0, vbr:0, spc:0, ssr:0, sgr:0, tea:0, pteh:0, ev:0, iev:0, tra:0, fw:0, tag:""};
    repeat (3) @(negedge clk);
    chk("R1", "upd", {31'd0, upd}, 32'd0);
    chk("R1", "new_pc", new_pc, 32'd0);
    chk("R1", "saved_pc", saved_pc, 32'd0);
    chk("R1", "expevt", {20'd0, expevt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fpscr_wr", {31'd0, fpscr_wr}, 32'd0);
    send(0, 12'h0, 0, 32'h1111_0000, 32'h0000_8003, 32'h55, 32'h1234_0000, 0, "R2");
    idle(2);
    send(2, 12'h1E0, 0, 32'h8C00_2000, 32'h4000_0001, 32'h8CFF_FFF0, 32'h8C00_0000, 0, "R4");
    idle(1);
    send(2, 12'h180, 0, 32'h8C00_3000, 32'h5000_80F1, 32'h1, 32'h8C00_0000, 0, "R5");
    idle(1);
    send(1, 12'h0, 0, 32'h0C00_0010, 32'h0000_8000, 32'h2, 32'h8C00_0000, 0, "R3");
    idle(1);
    send(3, 12'h0C3, 0, 32'h8C01_0000, 32'h5000_0000, 32'h8D00_0000, 32'h8C00_0000, 0, "R6");
    idle(1);
    send(4, 12'h040, 32'h1234_5678, 32'h0C00_4444, 32'h0000_00F0, 32'h3, 32'h8C00_0000, 32'hFFFF_F3AB, "R7");
    idle(1);
    send(6, 12'h320, 0, 32'h0C00_5556, 32'h4000_0010, 32'h4, 32'h8C00_0000, 0, "R9 R11");
    idle(1);
    send(5, 12'h0, 32'hDEAD_BEEF, 32'h0C00_6000, 32'h0000_8001, 32'h5, 32'h8C00_0000, 32'h0000_0155, "R8");
    idle(1);
    send(6, 12'h5A0, 0, 32'h0C00_7000, 32'h0, 32'h6, 32'h0000_0000, 0, "R10 irq");
    send(3, 12'hFF, 0, 32'h0C00_7002, 32'h1, 32'h7, 32'h0000_0000, 0, "R10 trap");
    send(4, 12'h060, 32'h0000_03FF, 32'h0C00_7004, 32'h2, 32'h8, 32'h0000_1000, 32'h1234_5678, "R10 tlb");
    idle(1);
    send(7, 12'h0E0, 0, 32'h0C00_8000, 32'h0, 32'h9, 32'h0000_2000, 0, "R4 cls7");
    idle(4);
    chk("R10", "queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule